// File: doc/BRIEF.md
# Sine-PWM H-Bridge Modulator

This block turns a DC bus into a 50 Hz single-phase output by driving the four gates of an H-bridge. A free-running carrier counter sets a 20 kHz switching period. At each period boundary the block steps through a built-in table of half-sine magnitudes and advances one entry. It scales the entry by a maximum-duty count from an outer voltage loop to get the compare value for the coming period. The table has 200 entries per half-cycle, so the carrier rate alone fixes the output frequency.

During the positive half-cycle, leg A switches: its high side and low side are complementary and separated by a programmable dead time. Leg B holds its low side on, so the diagonal pair A-high / B-low carries the pulses. During the negative half-cycle the roles of the two legs swap. A control state machine has two states. `ST_OFF` holds every gate low and rearms the sequence. `ST_RUN` modulates. The START transition (`ST_OFF` to `ST_RUN`) fires when enable is high and the active-low fault is released. The HALT transition (`ST_RUN` to `ST_OFF`) fires when either condition is lost. The fault input also gates the outputs without waiting for a clock.

Top module: `spwm_bridge`

## Requirements
- R1: While reset is asserted, and while the block sits in `ST_OFF`, all four gate outputs are low.
- R2: Once running, one carrier period lasts `CLK_PER_CARRIER` clocks, and exactly one table entry is used per period. Period p uses entry p mod 200. The outputs for the first period start two clocks after the edge that samples enable high.
- R3: The compare value for entry k is floor(T(k) * A / 4096), kept to the counter width, where T(k) = round(4095 * sin(pi * k / 200)) and A is the latched maximum-duty count. The switching leg's high side is on for clocks dt to cmp-1 of the period, where dt is the dead time, giving max(cmp - dt, 0) clocks.
- R4: In the positive half-cycle (the first 200 periods after start), leg A switches, and leg B keeps its low side on for the whole period with its high side off. The next 200 periods are negative: leg B switches and leg A is clamped low. The two then alternate.
- R5: The switching leg's low side is on from clock cmp + dt to the end of the period, which is `CLK_PER_CARRIER` - cmp - dt clocks. With a nonzero dead time, no gate of a leg turns on in the clock after its partner was on.
- R6: The compare value saturates at `CLK_PER_CARRIER` minus the dead time.
- R7: The maximum-duty and dead-time inputs are latched at start and at each half-cycle boundary only. A change during a half-cycle takes effect from the next half-cycle.
- R8: A low on `fault_n` forces all outputs low in the same clock. After release, the sequence restarts at entry 0 with positive polarity.
- R9: Dropping `enable` forces all outputs low from the next clock. Raising it again restarts at entry 0 with positive polarity.
- R10: A leg's high side and low side are never on together, and the two high sides are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request |
| fault_n | input | 1 | Overcurrent / short-circuit fault, active low |
| max_duty | input | CNT_W | Amplitude multiplier from the outer loop |
| dead_time | input | DT_W | Dead time in clocks between complementary gates |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |

## Verification
The assertions check the gate-safety rules on every cycle. They cover the exclusion between the two gates of each leg and between the two high sides, the dead-time gap at every gate turn-on, and the blanking caused by a fault or by dropping enable. The per-period pulse widths cannot be seen by a cycle property. These are the sine-shaped widths, the saturation at the peak, the polarity swap after 200 periods, the deferred pickup of a new amplitude, and the restart from entry 0. The bench's scenarios show them by counting the on-clocks of each gate in every carrier period against a model of the table.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    typedef enum logic [0:0] {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } half_pol_e;

endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
    parameter int SAMPLES = 200,
    parameter int MAG_W   = 12,
    parameter int IDX_W   = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] mag
);

    logic [MAG_W-1:0] rom [SAMPLES];

    // Half-sine magnitudes, 0 to 180 degrees exclusive of the end point.
    for (genvar i = 0; i < SAMPLES; i++) begin : g_entry
        localparam real ANGLE = 3.14159265358979 * i / SAMPLES;
        localparam int  VAL   = $rtoi(((2.0 ** MAG_W) - 1.0) * $sin(ANGLE) + 0.5);
        assign rom[i] = VAL[MAG_W-1:0];
    end

    always_comb begin
        if (int'(idx) < SAMPLES) begin
            mag = rom[idx];
        end else begin
            mag = '0;
        end
    end

endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
    parameter int PERIOD = 3000,
    parameter int CNT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(PERIOD - 1);

    assign last = run && (cnt == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spwm_leg.sv
module spwm_leg #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DT_W-1:0]  dt,
    input  logic             switching,
    output logic             hi,
    output logic             lo
);

    logic [CNT_W:0] cnt_x;
    logic [CNT_W:0] cmp_x;
    logic [CNT_W:0] dt_x;

    assign cnt_x = (CNT_W+1)'(cnt);
    assign cmp_x = (CNT_W+1)'(cmp);
    assign dt_x  = (CNT_W+1)'(dt);

    // A clamped leg keeps its low side on; a switching leg is complementary
    // with a dead-time gap before each turn-on.
    always_comb begin
        hi = switching && (cnt_x >= dt_x) && (cnt_x < cmp_x);
        lo = !switching || (cnt_x >= cmp_x + dt_x);
    end

endmodule

// File: rtl/spwm_bridge.sv
module spwm_bridge #(
    parameter int CLK_PER_CARRIER = 3000,
    parameter int CNT_W           = 12,
    parameter int SAMPLES         = 200,
    parameter int MAG_W           = 12,
    parameter int DT_W            = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fault_n,
    input  logic [CNT_W-1:0] max_duty,
    input  logic [DT_W-1:0]  dead_time,
    output logic             a_hi,
    output logic             a_lo,
    output logic             b_hi,
    output logic             b_lo
);
    import spwm_pkg::*;

    localparam int             IDX_W    = $clog2(SAMPLES);
    localparam int             PROD_W   = MAG_W + CNT_W;
    localparam logic [CNT_W:0] PERIOD_X = (CNT_W+1)'(CLK_PER_CARRIER);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);

    run_state_e        state_q, state_d;
    half_pol_e         pol_q;
    logic [IDX_W-1:0]  idx_q, idx_nxt;
    logic [CNT_W-1:0]  amp_q, amp_sel, cmp_q, cmp_nxt, scaled;
    logic [DT_W-1:0]   dt_q, dt_sel;
    logic [CNT_W-1:0]  cnt;
    logic              tick, running, go, wrap, reload;
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    logic [CNT_W:0]    lim;
    logic [1:0]        leg_hi, leg_lo;
    logic [3:0]        drv_q;

    assign go      = enable && fault_n;
    assign running = (state_q == ST_RUN);

    // Next-state logic: START and HALT transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: state_d = go ? ST_RUN : ST_OFF;
            ST_RUN: state_d = go ? ST_RUN : ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    spwm_carrier #(
        .PERIOD (CLK_PER_CARRIER),
        .CNT_W  (CNT_W)
    ) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .cnt   (cnt),
        .last  (tick)
    );

    // Sample sequencing and compare-value computation.
    assign wrap    = tick && (idx_q == LAST_IDX);
    assign reload  = !running || wrap;
    assign idx_nxt = (!running || wrap) ? '0 : idx_q + 1'b1;
    assign amp_sel = reload ? max_duty : amp_q;
    assign dt_sel  = reload ? dead_time : dt_q;

    spwm_sine_rom #(
        .SAMPLES (SAMPLES),
        .MAG_W   (MAG_W),
        .IDX_W   (IDX_W)
    ) u_rom (
        .idx (idx_nxt),
        .mag (mag)
    );

    always_comb begin
        prod    = PROD_W'(mag) * PROD_W'(amp_sel);
        scaled  = prod[PROD_W-1:MAG_W];
        lim     = PERIOD_X - (CNT_W+1)'(dt_sel);
        cmp_nxt = ({1'b0, scaled} > lim) ? lim[CNT_W-1:0] : scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            pol_q <= POL_POS;
            amp_q <= '0;
            dt_q  <= '0;
            cmp_q <= '0;
        end else if (!running) begin
            idx_q <= '0;
            pol_q <= POL_POS;
            amp_q <= max_duty;
            dt_q  <= dead_time;
            cmp_q <= cmp_nxt;
        end else if (tick) begin
            idx_q <= idx_nxt;
            amp_q <= amp_sel;
            dt_q  <= dt_sel;
            cmp_q <= cmp_nxt;
            if (wrap) begin
                pol_q <= (pol_q == POL_POS) ? POL_NEG : POL_POS;
            end
        end
    end

    // Leg 0 is A, leg 1 is B; the polarity picks which one switches.
    for (genvar g = 0; g < 2; g++) begin : g_leg
        logic sw;
        assign sw = (g == 0) ? (pol_q == POL_POS) : (pol_q == POL_NEG);
        spwm_leg #(
            .CNT_W (CNT_W),
            .DT_W  (DT_W)
        ) u_leg (
            .cnt       (cnt),
            .cmp       (cmp_q),
            .dt        (dt_q),
            .switching (sw),
            .hi        (leg_hi[g]),
            .lo        (leg_lo[g])
        );
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: drv_q <= go ? {leg_lo[1], leg_hi[1], leg_lo[0], leg_hi[0]} : 4'b0000;
                ST_OFF: drv_q <= 4'b0000;
            endcase
        end
    end

    // Fault blanking acts without waiting for a clock edge.
    assign a_hi = drv_q[0] & fault_n;
    assign a_lo = drv_q[1] & fault_n;
    assign b_hi = drv_q[2] & fault_n;
    assign b_lo = drv_q[3] & fault_n;

endmodule

// File: rtl/spwm_bridge_chk.sv
module spwm_bridge_chk #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            fault_n,
    input logic [DT_W-1:0] dead_time,
    input logic            a_hi,
    input logic            a_lo,
    input logic            b_hi,
    input logic            b_lo
);

    p_leg_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && a_lo) && !(b_hi && b_lo));

    p_high_sides_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && b_hi));

    p_dead_a_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $rose(a_lo)) |-> !$past(a_hi));

    p_dead_a_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $rose(a_hi)) |-> !$past(a_lo));

    p_dead_b_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $rose(b_lo)) |-> !$past(b_hi));

    p_dead_b_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $rose(b_hi)) |-> !$past(b_lo));

    p_fault_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> !(a_hi || a_lo || b_hi || b_lo));

    p_disable_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(a_hi || a_lo || b_hi || b_lo));

endmodule

bind spwm_bridge spwm_bridge_chk #(.DT_W(DT_W)) u_chk (.*);

// File: tb/spwm_bridge_bench.sv
module spwm_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PER        = 64;
    localparam int CNT_W      = 12;
    localparam int DT_W       = 8;
    localparam int NVEC       = 4;

    // Stimulus (amplitude, dead time) and expected peak high-side on-time at entry 100.
    localparam int VEC_AMP  [NVEC] = '{64, 32, 0, 100};
    localparam int VEC_DT   [NVEC] = '{2, 3, 1, 4};
    localparam int VEC_PEAK [NVEC] = '{60, 28, 0, 56};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             fault_n = 1'b1;
    logic [CNT_W-1:0] max_duty = '0;
    logic [DT_W-1:0]  dead_time = 8'd2;
    logic             a_hi, a_lo, b_hi, b_lo;

    int n_checks = 0;
    int n_fail   = 0;
    int overlaps = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spwm_bridge #(
        .CLK_PER_CARRIER (PER),
        .CNT_W           (CNT_W),
        .DT_W            (DT_W)
    ) u_spwm_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fault_n   (fault_n),
        .max_duty  (max_duty),
        .dead_time (dead_time),
        .a_hi      (a_hi),
        .a_lo      (a_lo),
        .b_hi      (b_hi),
        .b_lo      (b_lo)
    );

    function automatic int sine_mag(int k);
        return $rtoi(4095.0 * $sin(3.14159265358979 * k / 200.0) + 0.5);
    endfunction

    task automatic check(string tag, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic start_run(int amp, int dt);
        @(negedge clk);
        max_duty  = CNT_W'(amp);
        dead_time = DT_W'(dt);
        enable    = 1'b1;
        @(posedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk);
        @(posedge clk);
    endtask

    // Counts gate on-clocks per carrier period and compares with the model.
    task automatic measure(input int first_p, input int n, input int amp0, input int amp1,
                           input int dt, output int bad_sw, output int bad_cl,
                           output int peak_hi);
        bad_sw  = 0;
        bad_cl  = 0;
        peak_hi = -1;
        for (int p = first_p; p < first_p + n; p++) begin
            int k, neg, amp, cmpv, exp_hi, exp_lo;
            int c_ah, c_al, c_bh, c_bl, sw_h, sw_l, cl_h, cl_l;
            k    = p % 200;
            neg  = (p / 200) % 2;
            amp  = ((p / 200) == 0) ? amp0 : amp1;
            cmpv = ((sine_mag(k) * amp) >> 12) & 4095;
            if (cmpv > PER - dt) cmpv = PER - dt;
            exp_hi = (cmpv > dt) ? cmpv - dt : 0;
            exp_lo = PER - cmpv - dt;
            c_ah = 0; c_al = 0; c_bh = 0; c_bl = 0;
            for (int c = 0; c < PER; c++) begin
                @(posedge clk);
                #1;
                c_ah += int'(a_hi);
                c_al += int'(a_lo);
                c_bh += int'(b_hi);
                c_bl += int'(b_lo);
                if ((a_hi && a_lo) || (b_hi && b_lo) || (a_hi && b_hi)) overlaps++;
            end
            sw_h = neg ? c_bh : c_ah;
            sw_l = neg ? c_bl : c_al;
            cl_h = neg ? c_ah : c_bh;
            cl_l = neg ? c_al : c_bl;
            if (sw_h != exp_hi || sw_l != exp_lo) bad_sw++;
            if (cl_h != 0 || cl_l != PER) bad_cl++;
            if (p == 100) peak_hi = sw_h;
        end
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stimulus
        int bsw, bcl, pk;

        // R1: outputs low under reset.
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset outputs", int'({a_hi, a_lo, b_hi, b_lo}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: one full output cycle per entry (R2 R3 R4 R5 R6).
        for (int v = 0; v < NVEC; v++) begin
            start_run(VEC_AMP[v], VEC_DT[v]);
            measure(0, 400, VEC_AMP[v], VEC_AMP[v], VEC_DT[v], bsw, bcl, pk);
            check($sformatf("R3 R5 switching leg widths, vector %0d (bad periods)", v), bsw, 0);
            check($sformatf("R2 R4 clamped leg, vector %0d (bad periods)", v), bcl, 0);
            check($sformatf("R6 peak high-side on-time, vector %0d", v), pk, VEC_PEAK[v]);
            stop_run();
        end

        // R7: amplitude change mid half-cycle only applies at the boundary.
        start_run(32, 2);
        measure(0, 50, 32, 64, 2, bsw, bcl, pk);
        max_duty = 12'd64;
        begin
            int bsw2, bcl2, pk2;
            measure(50, 200, 32, 64, 2, bsw2, bcl2, pk2);
            check("R7 deferred amplitude (bad periods)", bsw + bsw2 + bcl + bcl2, 0);
        end

        // R8: fault blanks at once, then restart from entry 0, positive.
        @(negedge clk);
        fault_n = 1'b0;
        #1;
        check("R8 fault blanking", int'({a_hi, a_lo, b_hi, b_lo}), 0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        fault_n = 1'b1;
        @(posedge clk);
        measure(0, 120, 64, 64, 2, bsw, bcl, pk);
        check("R8 restart after fault (bad periods)", bsw + bcl, 0);

        // R9: disable blanks from the next clock, then restart.
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk);
        #1;
        check("R9 disable blanking", int'({a_hi, a_lo, b_hi, b_lo}), 0);
        @(posedge clk);
        start_run(32, 3);
        measure(0, 5, 32, 32, 3, bsw, bcl, pk);
        check("R9 restart after enable (bad periods)", bsw + bcl, 0);
        stop_run();

        // R10: no gate overlap seen in any measured clock.
        check("R10 gate overlap clocks", overlaps, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule